// File: doc/BRIEF.md
# Thread Synchronization and Operand Preload Scheduler

This block manages the life cycle of non-blocking threads in a processor that keeps memory traffic apart from execution. Software or a neighbouring unit loads a thread descriptor: an initial synchronization count, a memory base address, the number of input words, the number of result words and a code start address. Each arriving input decrements that thread's count. A thread whose count reaches zero becomes enabled. The block then claims one of a small pool of register contexts for it and copies its input words from memory into that context.

Only after every input word has landed does the thread enter the ready queue that feeds the execution pipeline. The pipeline reads and writes the context through a private register port and never touches memory itself. When the pipeline reports that a context's thread has finished, the block writes the result words back to memory and returns the context to the pool.

Read requests carry a tag naming the context and the word, and responses may return in any order. A slow response for one thread therefore never holds back the memory requests or the dispatch of another thread.

Top module: `synch_sched`

## Requirements
- R1: After reset no memory request is raised, the ready output is not valid and the error flag is low.
- R2: A loaded thread with count N is enabled only after N decrements addressed to it, and no memory request for it appears before that.
- R3: An enabled thread takes the lowest-numbered free context and issues reads of addresses base+0 up to base+inLen-1 in that order, each tagged with the context number in the upper tag bits and the word index in the lower 3 bits; the returned data lands in register i of that context.
- R4: A thread enters the ready queue only after every read response for its context has returned.
- R5: The ready queue is a first-in first-out of {context, start address} pairs with a valid/ready handshake; while ready is low the head entry stays valid and unchanged.
- R6: A decrement to a thread with no remaining count (not loaded, already enabled, or running) raises the error flag for exactly one cycle, one clock later, and causes no memory request or dispatch.
- R7: A completion report for a context writes registers 0 up to outLen-1 of that context to addresses base+inLen+i, then frees that context for reuse.
- R8: Read responses may return out of order; a thread whose responses are quick is dispatched ahead of an earlier thread still waiting on a slow response.
- R9: There are four contexts; while none is free an enabled thread waits with no memory request, and when several threads are enabled at once the lowest-numbered one is started first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Load a thread descriptor (taken only while the thread is unloaded) |
| cfgThread | input | 3 | Thread slot being loaded |
| cfgCount | input | 4 | Initial synchronization count |
| cfgBase | input | 16 | Memory base address of the thread's frame |
| cfgInLen | input | 4 | Number of input words to preload |
| cfgOutLen | input | 4 | Number of result words to poststore |
| cfgStart | input | 16 | Code start address handed to the pipeline |
| decValid | input | 1 | One input arrived for a thread |
| decThread | input | 3 | Thread receiving the input |
| syncErr | output | 1 | Pulse: decrement to a thread with no remaining count |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 = write (poststore), 0 = read (preload) |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 32 | Write data |
| memTag | output | 5 | Read tag {context, word index} |
| memReady | input | 1 | Memory accepts the request this cycle |
| rspValid | input | 1 | Read response valid |
| rspTag | input | 5 | Tag of the returned read |
| rspData | input | 32 | Returned read data |
| rdyValid | output | 1 | Ready queue head valid |
| rdyCtx | output | 2 | Context of the head thread |
| rdyStart | output | 16 | Start address of the head thread |
| rdyReady | input | 1 | Pipeline takes the head entry |
| doneValid | input | 1 | Pipeline reports a finished thread |
| doneCtx | input | 2 | Context of the finished thread |
| exWe | input | 1 | Pipeline register write |
| exCtx | input | 2 | Context for the pipeline write |
| exReg | input | 3 | Register for the pipeline write |
| exWdata | input | 32 | Pipeline write data |
| exRdCtx | input | 2 | Context for the pipeline read |
| exRdReg | input | 3 | Register for the pipeline read |
| exRdData | output | 32 | Pipeline read data (combinational) |

## Verification
The error flag is due one clock after the decrement that the design samples, so the bench drives the decrement on a falling edge and checks the flag on the next falling edge, then once more a cycle later for its fall. Memory requests are captured on the falling edge before the rising edge that accepts them. The bench memory answers each read a fixed number of cycles later, with one address window made slow, and every dispatch is compared on the cycle it is accepted against the bench's own count of reads still in flight for that context. Ordering results such as dispatch order, allocation and stalls are checked from logs after a wait long enough for every pending response, and register contents are read back through the pipeline port.

// File: rtl/synch_pkg.sv
package synch_pkg;

  typedef enum logic [1:0] {
    TH_IDLE,
    TH_WAIT,
    TH_RUN
  } thrState_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_PRE,
    ENG_POST
  } engState_t;

  typedef struct packed {
    logic pushQ;
    logic memWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/synch_dp.sv
module synch_dp
  import synch_pkg::*;
#(
  parameter int NCTX   = 4,
  parameter int NREG   = 8,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int QDEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strb,
  input  logic [$clog2(NCTX)-1:0]       pushCtx,
  input  logic [AW-1:0]                 pushStart,
  input  logic [$clog2(NCTX)-1:0]       postCtx,
  input  logic [$clog2(NREG)-1:0]       postIdx,
  output logic [DW-1:0]                 postData,
  input  logic                          rspValid,
  input  logic [$clog2(NCTX)+$clog2(NREG)-1:0] rspTag,
  input  logic [DW-1:0]                 rspData,
  input  logic                          exWe,
  input  logic [$clog2(NCTX)-1:0]       exCtx,
  input  logic [$clog2(NREG)-1:0]       exReg,
  input  logic [DW-1:0]                 exWdata,
  input  logic [$clog2(NCTX)-1:0]       exRdCtx,
  input  logic [$clog2(NREG)-1:0]       exRdReg,
  output logic [DW-1:0]                 exRdData,
  output logic [$clog2(QDEPTH+1)-1:0]   qCount,
  output logic                          rdyValid,
  output logic [$clog2(NCTX)-1:0]       rdyCtx,
  output logic [AW-1:0]                 rdyStart,
  input  logic                          rdyReady
);
  localparam int CXW   = $clog2(NCTX);
  localparam int RW    = $clog2(NREG);
  localparam int NWORD = NCTX * NREG;
  localparam int QAW   = $clog2(QDEPTH);

  // context register file: one word per (context, register)
  logic [DW-1:0] rf [NWORD];
  logic [CXW+RW-1:0] exIdx;
  assign exIdx = {exCtx, exReg};

  generate
    for (genvar w = 0; w < NWORD; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rf[w] <= '0;
        end else if (rspValid && rspTag == (CXW+RW)'(w)) begin
          rf[w] <= rspData;
        end else if (exWe && exIdx == (CXW+RW)'(w)) begin
          rf[w] <= exWdata;
        end
      end
    end
  endgenerate

  assign postData = strb.memWr ? rf[{postCtx, postIdx}] : '0;
  assign exRdData = rf[{exRdCtx, exRdReg}];

  // ready queue
  logic [CXW-1:0] qCtx   [QDEPTH];
  logic [AW-1:0]  qStart [QDEPTH];
  logic [QAW-1:0] wrPtr, rdPtr;
  logic           pop;

  assign pop      = rdyValid && rdyReady;
  assign rdyValid = (qCount != '0);
  assign rdyCtx   = qCtx[rdPtr];
  assign rdyStart = qStart[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        qCtx[i]   <= '0;
        qStart[i] <= '0;
      end
    end else begin
      if (strb.pushQ) begin
        qCtx[wrPtr]   <= pushCtx;
        qStart[wrPtr] <= pushStart;
        wrPtr         <= wrPtr + 1'b1;
      end
      if (pop) rdPtr <= rdPtr + 1'b1;
      case ({strb.pushQ, pop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushQ |-> (qCount < ($clog2(QDEPTH+1))'(QDEPTH)) || pop); // R5

  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdyValid && !rdyReady |=> rdyValid && $stable(rdyCtx) && $stable(rdyStart)); // R5

endmodule

// File: rtl/synch_ctrl.sv
module synch_ctrl
  import synch_pkg::*;
#(
  parameter int NTHR   = 6,
  parameter int NCTX   = 4,
  parameter int NREG   = 8,
  parameter int AW     = 16,
  parameter int CNTW   = 4,
  parameter int QDEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgValid,
  input  logic [$clog2(NTHR)-1:0]       cfgThread,
  input  logic [CNTW-1:0]               cfgCount,
  input  logic [AW-1:0]                 cfgBase,
  input  logic [$clog2(NREG+1)-1:0]     cfgInLen,
  input  logic [$clog2(NREG+1)-1:0]     cfgOutLen,
  input  logic [AW-1:0]                 cfgStart,
  input  logic                          decValid,
  input  logic [$clog2(NTHR)-1:0]       decThread,
  output logic                          syncErr,
  output logic                          memValid,
  output logic                          memWrite,
  output logic [AW-1:0]                 memAddr,
  output logic [$clog2(NCTX)+$clog2(NREG)-1:0] memTag,
  input  logic                          memReady,
  input  logic                          rspValid,
  input  logic [$clog2(NCTX)+$clog2(NREG)-1:0] rspTag,
  input  logic                          doneValid,
  input  logic [$clog2(NCTX)-1:0]       doneCtx,
  input  logic [$clog2(QDEPTH+1)-1:0]   qCount,
  output ctrlStrobe_t                   strb,
  output logic [$clog2(NCTX)-1:0]       pushCtx,
  output logic [AW-1:0]                 pushStart,
  output logic [$clog2(NCTX)-1:0]       postCtx,
  output logic [$clog2(NREG)-1:0]       postIdx
);
  localparam int TW   = $clog2(NTHR);
  localparam int CXW  = $clog2(NCTX);
  localparam int RW   = $clog2(NREG);
  localparam int LW   = $clog2(NREG+1);
  localparam int TAGW = CXW + RW;

  // thread table
  thrState_t     thState [NTHR];
  logic [CNTW-1:0] thCount [NTHR];
  logic [AW-1:0] thBase  [NTHR];
  logic [LW-1:0] thIn    [NTHR];
  logic [LW-1:0] thOut   [NTHR];
  logic [AW-1:0] thStart [NTHR];

  // context table
  logic [NCTX-1:0] ctxUsed, ctxIssuing, ctxPreload, postPend;
  logic [AW-1:0]   ctxBase  [NCTX];
  logic [LW-1:0]   ctxIn    [NCTX];
  logic [LW-1:0]   ctxOut   [NCTX];
  logic [LW-1:0]   ctxLeft  [NCTX];
  logic [TW-1:0]   ctxThr   [NCTX];
  logic [AW-1:0]   ctxStart [NCTX];

  engState_t       engState;
  logic [CXW-1:0]  engCtx;
  logic [LW-1:0]   engIdx;

  // selection logic
  logic [NTHR-1:0] enMask;
  logic [NCTX-1:0] readyMask;
  logic [TW-1:0]   pickThr;
  logic [CXW-1:0]  pickFree, pickPost, pickPush;
  logic            anyEn, anyFree, anyPush, room, decOk, lastBeat;
  logic [CXW-1:0]  rspCtx;

  assign rspCtx = rspTag[TAGW-1:RW];

  always_comb begin
    for (int t = 0; t < NTHR; t++)
      enMask[t] = (thState[t] == TH_WAIT) && (thCount[t] == '0);
    for (int c = 0; c < NCTX; c++)
      readyMask[c] = ctxPreload[c] && !ctxIssuing[c] && (ctxLeft[c] == '0);
    pickThr = '0; anyEn = 1'b0;
    for (int t = NTHR-1; t >= 0; t--)
      if (enMask[t]) begin pickThr = TW'(t); anyEn = 1'b1; end
    pickFree = '0; anyFree = 1'b0;
    pickPost = '0;
    pickPush = '0; anyPush = 1'b0;
    for (int c = NCTX-1; c >= 0; c--) begin
      if (!ctxUsed[c])   begin pickFree = CXW'(c); anyFree = 1'b1; end
      if (postPend[c])   pickPost = CXW'(c);
      if (readyMask[c])  begin pickPush = CXW'(c); anyPush = 1'b1; end
    end
    room     = (int'(qCount) + $countones(ctxPreload)) < QDEPTH;
    decOk    = (thState[decThread] == TH_WAIT) && (thCount[decThread] != '0);
    lastBeat = (LW'(engIdx + 1'b1) == (engState == ENG_POST ? ctxOut[engCtx] : ctxIn[engCtx]));
  end

  // memory request and datapath strobes
  assign memValid  = (engState != ENG_IDLE);
  assign memWrite  = (engState == ENG_POST);
  assign memAddr   = (engState == ENG_POST)
                     ? ctxBase[engCtx] + AW'(ctxIn[engCtx]) + AW'(engIdx)
                     : ctxBase[engCtx] + AW'(engIdx);
  assign memTag    = {engCtx, engIdx[RW-1:0]};
  assign postCtx   = engCtx;
  assign postIdx   = engIdx[RW-1:0];
  assign pushCtx   = pickPush;
  assign pushStart = ctxStart[pickPush];
  assign strb.pushQ = anyPush;
  assign strb.memWr = (engState == ENG_POST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncErr    <= 1'b0;
      ctxUsed    <= '0;
      ctxIssuing <= '0;
      ctxPreload <= '0;
      postPend   <= '0;
      engState   <= ENG_IDLE;
      engCtx     <= '0;
      engIdx     <= '0;
      for (int t = 0; t < NTHR; t++) begin
        thState[t] <= TH_IDLE;
        thCount[t] <= '0;
        thBase[t]  <= '0;
        thIn[t]    <= '0;
        thOut[t]   <= '0;
        thStart[t] <= '0;
      end
      for (int c = 0; c < NCTX; c++) begin
        ctxBase[c]  <= '0;
        ctxIn[c]    <= '0;
        ctxOut[c]   <= '0;
        ctxLeft[c]  <= '0;
        ctxThr[c]   <= '0;
        ctxStart[c] <= '0;
      end
    end else begin
      // synchronization counts
      syncErr <= 1'b0;
      if (decValid) begin
        if (decOk) thCount[decThread] <= thCount[decThread] - 1'b1;
        else       syncErr <= 1'b1;
      end
      if (cfgValid && thState[cfgThread] == TH_IDLE) begin
        thState[cfgThread] <= TH_WAIT;
        thCount[cfgThread] <= cfgCount;
        thBase[cfgThread]  <= cfgBase;
        thIn[cfgThread]    <= cfgInLen;
        thOut[cfgThread]   <= cfgOutLen;
        thStart[cfgThread] <= cfgStart;
      end

      // preload responses and ready-queue push
      if (rspValid && ctxLeft[rspCtx] != '0)
        ctxLeft[rspCtx] <= ctxLeft[rspCtx] - 1'b1;
      if (anyPush) ctxPreload[pickPush] <= 1'b0;
      if (doneValid) postPend[doneCtx] <= 1'b1;

      // memory engine
      case (engState)
        ENG_IDLE: begin
          if (postPend != '0) begin
            postPend[pickPost] <= 1'b0;
            if (ctxOut[pickPost] == '0) begin
              ctxUsed[pickPost]         <= 1'b0;
              thState[ctxThr[pickPost]] <= TH_IDLE;
            end else begin
              engState <= ENG_POST;
              engCtx   <= pickPost;
              engIdx   <= '0;
            end
          end else if (anyEn && anyFree && room) begin
            thState[pickThr]     <= TH_RUN;
            ctxUsed[pickFree]    <= 1'b1;
            ctxPreload[pickFree] <= 1'b1;
            ctxBase[pickFree]    <= thBase[pickThr];
            ctxIn[pickFree]      <= thIn[pickThr];
            ctxOut[pickFree]     <= thOut[pickThr];
            ctxThr[pickFree]     <= pickThr;
            ctxStart[pickFree]   <= thStart[pickThr];
            ctxLeft[pickFree]    <= thIn[pickThr];
            if (thIn[pickThr] != '0) begin
              ctxIssuing[pickFree] <= 1'b1;
              engState <= ENG_PRE;
              engCtx   <= pickFree;
              engIdx   <= '0;
            end
          end
        end
        ENG_PRE: begin
          if (memReady) begin
            if (lastBeat) begin
              ctxIssuing[engCtx] <= 1'b0;
              engState <= ENG_IDLE;
            end else begin
              engIdx <= engIdx + 1'b1;
            end
          end
        end
        ENG_POST: begin
          if (memReady) begin
            if (lastBeat) begin
              ctxUsed[engCtx]         <= 1'b0;
              thState[ctxThr[engCtx]] <= TH_IDLE;
              engState <= ENG_IDLE;
            end else begin
              engIdx <= engIdx + 1'b1;
            end
          end
        end
        default: engState <= ENG_IDLE;
      endcase
    end
  end

  AST_SYNC_ERR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    decValid && !decOk |=> syncErr); // R6

  AST_NO_ERR_ON_GOOD_DEC: assert property (@(posedge clk) disable iff (!rstN)
    decValid && decOk |=> !syncErr); // R6

  AST_REQ_OWNED_CTX: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> ctxUsed[engCtx]); // R3

  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ctxPreload[rspCtx] && (ctxLeft[rspCtx] != '0)); // R8

  AST_PUSH_PRELOADED: assert property (@(posedge clk) disable iff (!rstN)
    anyPush |=> !ctxPreload[$past(pickPush)]); // R4

  AST_FREE_AFTER_POST: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite && memReady && lastBeat |=> !ctxUsed[$past(engCtx)]); // R7

endmodule

// File: rtl/synch_sched.sv
module synch_sched
  import synch_pkg::*;
#(
  parameter int NTHR   = 6,
  parameter int NCTX   = 4,
  parameter int NREG   = 8,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int CNTW   = 4,
  parameter int QDEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgValid,
  input  logic [$clog2(NTHR)-1:0]       cfgThread,
  input  logic [CNTW-1:0]               cfgCount,
  input  logic [AW-1:0]                 cfgBase,
  input  logic [$clog2(NREG+1)-1:0]     cfgInLen,
  input  logic [$clog2(NREG+1)-1:0]     cfgOutLen,
  input  logic [AW-1:0]                 cfgStart,
  input  logic                          decValid,
  input  logic [$clog2(NTHR)-1:0]       decThread,
  output logic                          syncErr,
  output logic                          memValid,
  output logic                          memWrite,
  output logic [AW-1:0]                 memAddr,
  output logic [DW-1:0]                 memWdata,
  output logic [$clog2(NCTX)+$clog2(NREG)-1:0] memTag,
  input  logic                          memReady,
  input  logic                          rspValid,
  input  logic [$clog2(NCTX)+$clog2(NREG)-1:0] rspTag,
  input  logic [DW-1:0]                 rspData,
  output logic                          rdyValid,
  output logic [$clog2(NCTX)-1:0]       rdyCtx,
  output logic [AW-1:0]                 rdyStart,
  input  logic                          rdyReady,
  input  logic                          doneValid,
  input  logic [$clog2(NCTX)-1:0]       doneCtx,
  input  logic                          exWe,
  input  logic [$clog2(NCTX)-1:0]       exCtx,
  input  logic [$clog2(NREG)-1:0]       exReg,
  input  logic [DW-1:0]                 exWdata,
  input  logic [$clog2(NCTX)-1:0]       exRdCtx,
  input  logic [$clog2(NREG)-1:0]       exRdReg,
  output logic [DW-1:0]                 exRdData
);
  localparam int CXW = $clog2(NCTX);
  localparam int RW  = $clog2(NREG);
  localparam int QCW = $clog2(QDEPTH+1);

  ctrlStrobe_t    strb;
  logic [CXW-1:0] pushCtx, postCtx;
  logic [AW-1:0]  pushStart;
  logic [RW-1:0]  postIdx;
  logic [QCW-1:0] qCount;

  synch_ctrl #(
    .NTHR(NTHR), .NCTX(NCTX), .NREG(NREG), .AW(AW), .CNTW(CNTW), .QDEPTH(QDEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgThread(cfgThread), .cfgCount(cfgCount),
    .cfgBase(cfgBase), .cfgInLen(cfgInLen), .cfgOutLen(cfgOutLen), .cfgStart(cfgStart),
    .decValid(decValid), .decThread(decThread), .syncErr(syncErr),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memTag(memTag),
    .memReady(memReady), .rspValid(rspValid), .rspTag(rspTag),
    .doneValid(doneValid), .doneCtx(doneCtx), .qCount(qCount),
    .strb(strb), .pushCtx(pushCtx), .pushStart(pushStart),
    .postCtx(postCtx), .postIdx(postIdx)
  );

  synch_dp #(
    .NCTX(NCTX), .NREG(NREG), .AW(AW), .DW(DW), .QDEPTH(QDEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pushCtx(pushCtx), .pushStart(pushStart),
    .postCtx(postCtx), .postIdx(postIdx), .postData(memWdata),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData),
    .exWe(exWe), .exCtx(exCtx), .exReg(exReg), .exWdata(exWdata),
    .exRdCtx(exRdCtx), .exRdReg(exRdReg), .exRdData(exRdData),
    .qCount(qCount), .rdyValid(rdyValid), .rdyCtx(rdyCtx), .rdyStart(rdyStart),
    .rdyReady(rdyReady)
  );

endmodule

// File: tb/sim_synch_sched.sv
module sim_synch_sched;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 0;
  logic [2:0]  cfgThread = 0;
  logic [3:0]  cfgCount = 0;
  logic [15:0] cfgBase = 0;
  logic [3:0]  cfgInLen = 0, cfgOutLen = 0;
  logic [15:0] cfgStart = 0;
  logic        decValid = 0;
  logic [2:0]  decThread = 0;
  logic        syncErr;
  logic        memValid, memWrite;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic [4:0]  memTag;
  logic        memReady = 1'b1;
  logic        rspValid = 0;
  logic [4:0]  rspTag = 0;
  logic [31:0] rspData = 0;
  logic        rdyValid;
  logic [1:0]  rdyCtx;
  logic [15:0] rdyStart;
  logic        rdyReady = 1'b1;
  logic        doneValid = 0;
  logic [1:0]  doneCtx = 0;
  logic        exWe = 0;
  logic [1:0]  exCtx = 0;
  logic [2:0]  exReg = 0;
  logic [31:0] exWdata = 0;
  logic [1:0]  exRdCtx = 0;
  logic [2:0]  exRdReg = 0;
  logic [31:0] exRdData;

  always #10 clk = ~clk;

  synch_sched u0 (.*);

  int total = 0, bad = 0, cyc = 0;

  // behavioural memory and logs
  logic [31:0] mem [4096];
  int rdAddr [64]; int rdTag [64]; int rdN = 0;
  int wrAddr [64]; logic [31:0] wrData [64]; int wrN = 0;
  int dpCtx [64]; int dpStart [64]; int dpN = 0;
  int pAddr [64]; int pTag [64]; int pDue [64]; int pN = 0;
  int outst [4];

  function automatic logic [31:0] initVal(int a);
    return 32'hD000_0000 | 32'(a);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    rspValid <= 1'b0;
    if (rstN) begin
      // serve one due response
      for (int i = 0; i < pN; i++) begin
        if (pDue[i] <= cyc) begin
          rspValid <= 1'b1;
          rspTag   <= 5'(pTag[i]);
          rspData  <= mem[pAddr[i]];
          outst[pTag[i] >> 3]--;
          for (int j = i; j < pN - 1; j++) begin
            pAddr[j] = pAddr[j+1]; pTag[j] = pTag[j+1]; pDue[j] = pDue[j+1];
          end
          pN--;
          break;
        end
      end
      if (memValid && memReady) begin
        if (memWrite) begin
          mem[memAddr[11:0]] = memWdata;
          wrAddr[wrN] = int'(memAddr); wrData[wrN] = memWdata; wrN++;
        end else begin
          rdAddr[rdN] = int'(memAddr); rdTag[rdN] = int'(memTag); rdN++;
          pAddr[pN] = int'(memAddr[11:0]); pTag[pN] = int'(memTag);
          pDue[pN] = cyc + ((memAddr >= 16'h200 && memAddr < 16'h300) ? 40 : 2);
          pN++;
          outst[int'(memTag) >> 3]++;
        end
      end
      if (rdyValid && rdyReady) begin
        // R4: nothing may still be in flight for a dispatched context
        check(outst[rdyCtx] == 0, "R4 dispatch with reads in flight", outst[rdyCtx], 0);
        dpCtx[dpN] = int'(rdyCtx); dpStart[dpN] = int'(rdyStart); dpN++;
      end
    end
  end

  task automatic loadThr(input int t, input int cnt, input int base, input int inL,
                         input int outL, input int st);
    cfgValid = 1; cfgThread = 3'(t); cfgCount = 4'(cnt); cfgBase = 16'(base);
    cfgInLen = 4'(inL); cfgOutLen = 4'(outL); cfgStart = 16'(st);
    @(negedge clk);
    cfgValid = 0;
  endtask

  task automatic dec(input int t);
    decValid = 1; decThread = 3'(t);
    @(negedge clk);
    decValid = 0;
  endtask

  task automatic waitDisp(input int n);
    for (int k = 0; k < 300 && dpN < n; k++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic bit sawRead(int a);
    for (int i = 0; i < rdN; i++) if (rdAddr[i] == a) return 1;
    return 0;
  endfunction

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = initVal(a);
    for (int c = 0; c < 4; c++) outst[c] = 0;
  end

  // watchdog
  initial begin
    #(20ns * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(memValid == 0, "R1 memValid at reset", memValid, 0);
    check(rdyValid == 0, "R1 rdyValid at reset", rdyValid, 0);
    check(syncErr == 0,  "R1 syncErr at reset", syncErr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: two inputs needed
    loadThr(0, 2, 16'h100, 3, 2, 16'h00A0);
    dec(0);
    idle(6);
    check(rdN == 0, "R2 read before count reached zero", rdN, 0);
    dec(0);
    waitDisp(1);
    check(rdN == 3, "R3 preload read count", rdN, 3);
    for (int i = 0; i < 3; i++) begin
      check(rdAddr[i] == 16'h100 + i, "R3 preload address", rdAddr[i], 16'h100 + i);
      check(rdTag[i] == i, "R3 preload tag ctx0", rdTag[i], i);
    end
    check(dpN == 1 && dpCtx[0] == 0 && dpStart[0] == 16'h00A0, "R5 first dispatch entry",
          dpStart[0], 16'h00A0);
    for (int i = 0; i < 3; i++) begin
      exRdCtx = 0; exRdReg = 3'(i); #1;
      check(exRdData == initVal(16'h100 + i), "R3 preloaded register", exRdData,
            initVal(16'h100 + i));
    end

    // R6: decrement to a running thread
    n0 = rdN;
    dec(0);
    check(syncErr == 1, "R6 error pulse", syncErr, 1);
    @(negedge clk);
    check(syncErr == 0, "R6 error pulse one cycle", syncErr, 0);
    idle(5);
    check(rdN == n0 && dpN == 1 && !rdyValid, "R6 no side effect", rdN, n0);
    dec(5);
    check(syncErr == 1, "R6 error on unloaded thread", syncErr, 1);

    // R7: results written back
    exWe = 1; exCtx = 0; exReg = 0; exWdata = 32'h1111_1111;
    @(negedge clk);
    exReg = 1; exWdata = 32'h2222_2222;
    @(negedge clk);
    exWe = 0; doneValid = 1; doneCtx = 0;
    @(negedge clk);
    doneValid = 0;
    idle(10);
    check(wrN == 2, "R7 poststore count", wrN, 2);
    check(wrAddr[0] == 16'h103 && wrData[0] == 32'h1111_1111, "R7 first result", wrData[0],
          32'h1111_1111);
    check(wrAddr[1] == 16'h104 && wrData[1] == 32'h2222_2222, "R7 second result", wrData[1],
          32'h2222_2222);

    // R8 and R5: slow thread1, fast thread2, queue held
    rdyReady = 0;
    n0 = rdN;
    loadThr(1, 0, 16'h200, 2, 0, 16'h00B1);
    loadThr(2, 0, 16'h300, 2, 0, 16'h00B2);
    idle(8);
    check(rdN == n0 + 4, "R8 fast thread reads not held back", rdN, n0 + 4);
    check((rdTag[n0] >> 3) == 0, "R7 freed context reused", rdTag[n0] >> 3, 0);
    check((rdTag[n0+2] >> 3) == 1, "R3 next free context", rdTag[n0+2] >> 3, 1);
    check(rdyValid && rdyCtx == 1 && rdyStart == 16'h00B2, "R8 fast thread at head",
          rdyStart, 16'h00B2);
    idle(50);
    check(rdyValid && rdyCtx == 1 && rdyStart == 16'h00B2, "R5 head held while not ready",
          rdyStart, 16'h00B2);
    rdyReady = 1;
    waitDisp(3);
    check(dpCtx[1] == 1 && dpStart[1] == 16'h00B2, "R8 fast thread dispatched first",
          dpStart[1], 16'h00B2);
    check(dpCtx[2] == 0 && dpStart[2] == 16'h00B1, "R5 order kept", dpStart[2], 16'h00B1);
    exRdCtx = 0; exRdReg = 1; #1;
    check(exRdData == initVal(16'h201), "R8 slow data stored", exRdData, initVal(16'h201));

    // R9: pool exhaustion and lowest-thread priority
    loadThr(5, 0, 16'h600, 1, 1, 16'h00C5);
    loadThr(4, 0, 16'h500, 1, 1, 16'h00C4);
    loadThr(3, 0, 16'h400, 1, 1, 16'h00C3);
    waitDisp(5);
    idle(20);
    check(dpN == 5, "R9 only two more dispatched", dpN, 5);
    check(dpCtx[3] == 2 && dpStart[3] == 16'h00C5, "R9 first enabled takes ctx2", dpStart[3],
          16'h00C5);
    check(dpCtx[4] == 3 && dpStart[4] == 16'h00C3, "R9 lowest thread chosen", dpStart[4],
          16'h00C3);
    check(!sawRead(16'h500), "R9 no read while pool is empty", sawRead(16'h500), 0);
    doneValid = 1; doneCtx = 1;
    @(negedge clk);
    doneValid = 0;
    waitDisp(6);
    check(dpN == 6 && dpCtx[5] == 1 && dpStart[5] == 16'h00C4, "R9 waiting thread gets freed ctx",
          dpStart[5], 16'h00C4);
    check(sawRead(16'h500), "R9 read after context freed", sawRead(16'h500), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule